// File: doc/BRIEF.md
# In-Order Five-Stage Integer Pipeline

This block executes a small 32-bit integer instruction set in an in-order pipeline with five stages: fetch, decode, execute, memory and write-back. A separate register sits between each pair of neighbouring stages and is loaded on every clock edge. Up to five instructions are in flight at once. Each instruction still needs five cycles from fetch to write-back, but a new instruction can enter every cycle.

Instruction fetch and data access use two independent memory ports, so a fetch never competes with a load or a store. Both ports expect a combinational read. The data port writes on the clock edge while `dmemWe` is high. Conditional branches are resolved late, in the memory stage. When a branch is taken, the three younger instructions already in the pipeline are turned into no-ops. There is no forwarding. A decode-stage instruction that needs a result which is not yet written back is held in decode, and a bubble is inserted behind it.

Top module: `pipe_core`

## Requirements
- R1: While `rstN` is low, `imemAddr` is 0 and `dmemWe` is 0. In the first cycle after release, the fetch address is 0 and no pipeline stage holds a valid instruction.
- R2: Instruction fields are as follows:
  - opcode is bits 31:26.
  - source A is bits 25:21.
  - source B is bits 20:16.
  - the destination is bits 15:11 for register-register operations and bits 20:16 for the immediate add and the load.
  - the function code is bits 10:0.
  - the immediate is bits 15:0, sign-extended.
- R3: Opcode 0x00 is a register-register operation, and its function code selects the result:
  - 0x020 gives A+B.
  - 0x022 gives A-B.
  - 0x024 gives AND.
  - 0x025 gives OR.
  - 0x026 gives XOR.
  - 0x02A gives a signed less-than (1 or 0).
  - any other code gives A+B.
  Opcode 0x08 writes A+imm to its destination.
- R4: A load (opcode 0x23) reads word A+imm into its destination. A store (opcode 0x2B) writes register B to byte address A+imm. The data port is driven from the memory stage.
- R5: Without stalls, one instruction enters per cycle. A store fetched in cycle k asserts `dmemWe` in cycle k+3.
- R6: Opcode 0x04 branches if A is 0, and opcode 0x05 branches if A is not 0. The target is the fall-through address (branch address + 4) plus imm. A branch in the memory stage in cycle t sets `imemAddr` to the target in cycle t+1. A branch that is not taken does not redirect fetch.
- R7: On a taken branch, the three instructions fetched after it neither store nor write a register.
- R8: An instruction whose source register matches the destination of an instruction in execute or memory stalls in decode. The fetch address holds during the stall, and a bubble follows the stalled instruction. A write-back in the same cycle as the decode read is seen by that read. As a result, a dependent instruction placed directly after its producer waits two cycles, and one placed two slots later waits one cycle.
- R9: Register 0 always reads 0. Writes to it are discarded.
- R10: Any opcode not listed in R3, R4 or R6 has no effect on registers, memory or fetch order.
- R11: After a program runs to completion, the data memory matches the result of executing the same program one instruction at a time in program order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| imemAddr | output | 32 | Byte address of the instruction being fetched |
| imemData | input | 32 | Instruction word at `imemAddr` |
| dmemAddr | output | 32 | Byte address of the load or store in the memory stage |
| dmemWrData | output | 32 | Store data |
| dmemWe | output | 1 | Store strobe for the current cycle |
| dmemRdData | input | 32 | Load data at `dmemAddr` |

## Verification
The interior of the block is only visible through the two memory ports. A fault in a stage register or in the hazard logic therefore appears in one of two ways:
- as a store in the wrong cycle, with the wrong address or with the wrong data;
- as a fetch address that fails to hold or fails to jump.

A corrupted stage register shows up on the data port within three cycles of the instruction reaching execute. A missed stall or a missed squash may only become visible in the final memory image. The bench therefore checks both the cycle of each store and the final image, comparing the image against an instruction-by-instruction model.

// File: rtl/pipe_pkg.sv
`timescale 1ns/1ps
package pipe_pkg;
  localparam int ILEN = 32;
  localparam int RIDX = 5;

  localparam logic [5:0] OP_ALU  = 6'h00;
  localparam logic [5:0] OP_BEQZ = 6'h04;
  localparam logic [5:0] OP_BNEZ = 6'h05;
  localparam logic [5:0] OP_ADDI = 6'h08;
  localparam logic [5:0] OP_LW   = 6'h23;
  localparam logic [5:0] OP_SW   = 6'h2B;

  localparam logic [10:0] FN_SUB = 11'h022;
  localparam logic [10:0] FN_AND = 11'h024;
  localparam logic [10:0] FN_OR  = 11'h025;
  localparam logic [10:0] FN_XOR = 11'h026;
  localparam logic [10:0] FN_SLT = 11'h02A;

  // strobes from control into the datapath
  typedef struct packed {
    logic stallId;
    logic flushYoung;
  } pipeCtl_t;

  // status from the datapath back to control
  typedef struct packed {
    logic [RIDX-1:0] idRsA;
    logic [RIDX-1:0] idRsB;
    logic            idUseA;
    logic            idUseB;
    logic [RIDX-1:0] exDest;
    logic [RIDX-1:0] memDest;
    logic            memTaken;
  } pipeSts_t;

  function automatic logic readsA(input logic [5:0] op);
    return (op == OP_ALU) || (op == OP_ADDI) || (op == OP_LW) ||
           (op == OP_SW) || (op == OP_BEQZ) || (op == OP_BNEZ);
  endfunction

  function automatic logic readsB(input logic [5:0] op);
    return (op == OP_ALU) || (op == OP_SW);
  endfunction

  function automatic logic [RIDX-1:0] destOf(input logic [ILEN-1:0] ir);
    case (ir[31:26])
      OP_ALU:         return ir[15:11];
      OP_ADDI, OP_LW: return ir[20:16];
      default:        return '0;
    endcase
  endfunction
endpackage

// File: rtl/pipe_ctrl.sv
`timescale 1ns/1ps
module pipe_ctrl
  import pipe_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  pipeSts_t sts,
  output pipeCtl_t ctl
);
  logic hazA, hazB;

  always_comb begin
    hazA = sts.idUseA && (sts.idRsA != '0) &&
           ((sts.idRsA == sts.exDest) || (sts.idRsA == sts.memDest));
    hazB = sts.idUseB && (sts.idRsB != '0) &&
           ((sts.idRsB == sts.exDest) || (sts.idRsB == sts.memDest));
    ctl.stallId    = hazA || hazB;
    ctl.flushYoung = sts.memTaken;
  end

  // R8
  bubble_ins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.stallId && !ctl.flushYoung) |=> (sts.exDest == '0));

  // R8
  id_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.stallId && !ctl.flushYoung) |=> ($stable(sts.idRsA) && $stable(sts.idRsB)));
endmodule

// File: rtl/pipe_datapath.sv
`timescale 1ns/1ps
module pipe_datapath
  import pipe_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NREG = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  pipeCtl_t        ctl,
  output pipeSts_t        sts,
  output logic [XLEN-1:0] imemAddr,
  input  logic [ILEN-1:0] imemData,
  output logic [XLEN-1:0] dmemAddr,
  output logic [XLEN-1:0] dmemWrData,
  output logic            dmemWe,
  input  logic [XLEN-1:0] dmemRdData
);
  localparam int IMMW = 16;

  logic [XLEN-1:0] pc;
  // fetch/decode buffer
  logic [ILEN-1:0] fdIr;
  logic [XLEN-1:0] fdNpc;
  // decode/execute buffer
  logic [XLEN-1:0] deA, deB, deImm, deNpc;
  logic [RIDX-1:0] deDest;
  logic [5:0]      deOp;
  logic [10:0]     deFn;
  // execute/memory buffer
  logic [XLEN-1:0] amAlu, amB;
  logic            amCond;
  logic [RIDX-1:0] amDest;
  logic [5:0]      amOp;
  // memory/write-back buffer
  logic [XLEN-1:0] mwLmd, mwAlu;
  logic [RIDX-1:0] mwDest;
  logic [5:0]      mwOp;

  logic [XLEN-1:0] rf [NREG];

  logic [5:0]      idOp;
  logic [RIDX-1:0] idRsA, idRsB;
  logic [XLEN-1:0] idA, idB, idImm, wbData, exAlu;
  logic            wbWe, exCond;

  // decode: register read with same-cycle write-back visible
  always_comb begin
    idOp   = fdIr[31:26];
    idRsA  = fdIr[25:21];
    idRsB  = fdIr[20:16];
    idImm  = {{(XLEN-IMMW){fdIr[IMMW-1]}}, fdIr[IMMW-1:0]};
    wbWe   = (mwDest != '0);
    wbData = (mwOp == OP_LW) ? mwLmd : mwAlu;
    if (idRsA == '0)                     idA = '0;
    else if (wbWe && (mwDest == idRsA))  idA = wbData;
    else                                 idA = rf[idRsA];
    if (idRsB == '0)                     idB = '0;
    else if (wbWe && (mwDest == idRsB))  idB = wbData;
    else                                 idB = rf[idRsB];
  end

  // execute
  always_comb begin
    exCond = 1'b0;
    exAlu  = deA + deImm;
    case (deOp)
      OP_ALU: begin
        case (deFn)
          FN_SUB:  exAlu = deA - deB;
          FN_AND:  exAlu = deA & deB;
          FN_OR:   exAlu = deA | deB;
          FN_XOR:  exAlu = deA ^ deB;
          FN_SLT:  exAlu = {{(XLEN-1){1'b0}}, ($signed(deA) < $signed(deB))};
          default: exAlu = deA + deB;
        endcase
      end
      OP_BEQZ: begin exAlu = deNpc + deImm; exCond = (deA == '0); end
      OP_BNEZ: begin exAlu = deNpc + deImm; exCond = (deA != '0); end
      default: exAlu = deA + deImm;
    endcase
  end

  always_comb begin
    imemAddr     = pc;
    dmemAddr     = amAlu;
    dmemWrData   = amB;
    dmemWe       = (amOp == OP_SW);
    sts.idRsA    = idRsA;
    sts.idRsB    = idRsB;
    sts.idUseA   = readsA(idOp);
    sts.idUseB   = readsB(idOp);
    sts.exDest   = deDest;
    sts.memDest  = amDest;
    sts.memTaken = amCond;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc <= '0; fdIr <= '0; fdNpc <= '0;
      deA <= '0; deB <= '0; deImm <= '0; deNpc <= '0; deDest <= '0; deOp <= '0; deFn <= '0;
      amAlu <= '0; amB <= '0; amCond <= 1'b0; amDest <= '0; amOp <= '0;
      mwLmd <= '0; mwAlu <= '0; mwDest <= '0; mwOp <= '0;
    end else begin
      if (ctl.flushYoung)     pc <= amAlu;
      else if (!ctl.stallId)  pc <= pc + XLEN'(4);

      if (ctl.flushYoung) begin
        fdIr <= '0; fdNpc <= '0;
      end else if (!ctl.stallId) begin
        fdIr <= imemData; fdNpc <= pc + XLEN'(4);
      end

      if (ctl.flushYoung || ctl.stallId) begin
        deA <= '0; deB <= '0; deImm <= '0; deNpc <= '0; deDest <= '0; deOp <= OP_ALU; deFn <= '0;
      end else begin
        deA <= idA; deB <= idB; deImm <= idImm; deNpc <= fdNpc;
        deDest <= destOf(fdIr); deOp <= idOp; deFn <= fdIr[10:0];
      end

      if (ctl.flushYoung) begin
        amAlu <= '0; amB <= '0; amCond <= 1'b0; amDest <= '0; amOp <= OP_ALU;
      end else begin
        amAlu <= exAlu; amB <= deB; amCond <= exCond; amDest <= deDest; amOp <= deOp;
      end

      mwLmd <= dmemRdData; mwAlu <= amAlu; mwDest <= amDest; mwOp <= amOp;
    end
  end

  // register file, written in write-back
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else if (wbWe) begin
      rf[mwDest] <= wbData;
    end
  end

  // R5
  pc_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.stallId && !ctl.flushYoung) |=> (pc == $past(pc) + XLEN'(4)));

  // R6
  redirect_chk: assert property (@(posedge clk) disable iff (!rstN)
    amCond |=> (imemAddr == $past(amAlu)));

  // R7
  squash_chk: assert property (@(posedge clk) disable iff (!rstN)
    amCond |=> !dmemWe ##1 !dmemWe ##1 !dmemWe);

  // R8
  stall_pc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.stallId && !ctl.flushYoung) |=> $stable(pc));
endmodule

// File: rtl/pipe_core.sv
`timescale 1ns/1ps
module pipe_core
  import pipe_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rstN,
  output logic [XLEN-1:0] imemAddr,
  input  logic [ILEN-1:0] imemData,
  output logic [XLEN-1:0] dmemAddr,
  output logic [XLEN-1:0] dmemWrData,
  output logic            dmemWe,
  input  logic [XLEN-1:0] dmemRdData
);
  pipeCtl_t ctl;
  pipeSts_t sts;

  pipe_ctrl uCtrl (
    .clk  (clk),
    .rstN (rstN),
    .sts  (sts),
    .ctl  (ctl)
  );

  pipe_datapath #(.XLEN(XLEN), .NREG(32)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .sts        (sts),
    .imemAddr   (imemAddr),
    .imemData   (imemData),
    .dmemAddr   (dmemAddr),
    .dmemWrData (dmemWrData),
    .dmemWe     (dmemWe),
    .dmemRdData (dmemRdData)
  );
endmodule

// File: tb/sim_pipe_core.sv
`timescale 1ns/1ps
module sim_pipe_core;
  localparam int MW = 64;
  localparam int LOGN = 40;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] imemAddr, imemData, dmemAddr, dmemWrData, dmemRdData;
  logic        dmemWe;

  logic [31:0] imem [MW];
  logic [31:0] dmem [MW];
  logic [31:0] initMem [MW];
  logic [31:0] expMem [MW];
  logic [31:0] mr [32];
  logic        logWe [LOGN];
  logic [31:0] logAddr [LOGN];
  logic [31:0] logData [LOGN];
  logic [31:0] logPc [LOGN];

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pipe_core u0 (
    .clk(clk), .rstN(rstN), .imemAddr(imemAddr), .imemData(imemData),
    .dmemAddr(dmemAddr), .dmemWrData(dmemWrData), .dmemWe(dmemWe), .dmemRdData(dmemRdData)
  );

  assign imemData   = imem[imemAddr[7:2]];
  assign dmemRdData = dmem[dmemAddr[7:2]];

  always @(posedge clk) if (rstN && dmemWe) dmem[dmemAddr[7:2]] = dmemWrData;

  function automatic logic [31:0] encR(int fn, int rd, int ra, int rb);
    return {6'h00, ra[4:0], rb[4:0], rd[4:0], fn[10:0]};
  endfunction

  function automatic logic [31:0] encI(int op, int ra, int rb, int imm);
    return {op[5:0], ra[4:0], rb[4:0], imm[15:0]};
  endfunction

  localparam logic [31:0] HALT = {6'h04, 5'd0, 5'd0, 16'hFFFC};

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic clearProg();
    for (int i = 0; i < MW; i++) begin
      imem[i] = HALT;
      initMem[i] = (i * 32'h01030507) ^ 32'hA5A5_0F0F;
    end
  endtask

  task automatic runDut(int n, bit checkReset);
    rstN = 1'b0;
    for (int i = 0; i < MW; i++) dmem[i] = initMem[i];
    repeat (2) @(negedge clk);
    #1;
    if (checkReset) begin
      chk(imemAddr == 0, "R1", "fetch address in reset", imemAddr, 0);
      chk(dmemWe == 1'b0, "R1", "store strobe in reset", {31'd0, dmemWe}, 0);
    end
    @(negedge clk);
    rstN = 1'b1;
    for (int c = 0; c < n; c++) begin
      #1;
      if (c < LOGN) begin
        logWe[c] = dmemWe; logAddr[c] = dmemAddr; logData[c] = dmemWrData; logPc[c] = imemAddr;
      end
      @(negedge clk);
    end
  endtask

  // instruction-level reference model
  task automatic modelRun();
    int pc = 0;
    for (int i = 0; i < 32; i++) mr[i] = 0;
    for (int i = 0; i < MW; i++) expMem[i] = initMem[i];
    for (int s = 0; s < 4000; s++) begin
      logic [31:0] ir, imm, res, npc, ea;
      ir = imem[(pc >> 2) % MW];
      if (ir == HALT) break;
      imm = {{16{ir[15]}}, ir[15:0]};
      npc = pc + 4;
      ea  = mr[ir[25:21]] + imm;
      case (ir[31:26])
        6'h00: begin
          case (ir[10:0])
            11'h022: res = mr[ir[25:21]] - mr[ir[20:16]];
            11'h024: res = mr[ir[25:21]] & mr[ir[20:16]];
            11'h025: res = mr[ir[25:21]] | mr[ir[20:16]];
            11'h026: res = mr[ir[25:21]] ^ mr[ir[20:16]];
            11'h02A: res = ($signed(mr[ir[25:21]]) < $signed(mr[ir[20:16]])) ? 1 : 0;
            default: res = mr[ir[25:21]] + mr[ir[20:16]];
          endcase
          mr[ir[15:11]] = res;
        end
        6'h08: mr[ir[20:16]] = ea;
        6'h23: mr[ir[20:16]] = expMem[ea[7:2]];
        6'h2B: expMem[ea[7:2]] = mr[ir[20:16]];
        6'h04: if (mr[ir[25:21]] == 0) npc = npc + imm;
        6'h05: if (mr[ir[25:21]] != 0) npc = npc + imm;
        default: ;
      endcase
      mr[0] = 0;
      pc = npc;
    end
  endtask

  task automatic cmpMem(string req, string what);
    int badIdx = -1;
    for (int i = MW - 1; i >= 0; i--) if (dmem[i] !== expMem[i]) badIdx = i;
    if (badIdx < 0) chk(1'b1, req, what, 0, 0);
    else chk(1'b0, req, what, dmem[badIdx], expMem[badIdx]);
  endtask

  task automatic genRandom();
    int fns[7] = '{32'h020, 32'h022, 32'h024, 32'h025, 32'h026, 32'h02A, 32'h011};
    clearProg();
    for (int i = 0; i < 40; i++) begin
      int kind = $urandom_range(0, 9);
      int ra = $urandom_range(0, 7);
      int rb = $urandom_range(0, 7);
      int rd = $urandom_range(0, 7);
      case (kind)
        0, 1, 2: imem[i] = encR(fns[$urandom_range(0, 6)], rd, ra, rb);
        5:       imem[i] = encI(6'h23, 0, rb, 4 * $urandom_range(0, 63));
        6:       imem[i] = encI(6'h2B, 0, rb, 4 * $urandom_range(0, 47));
        7:       imem[i] = encI($urandom_range(0, 1) ? 6'h05 : 6'h04, ra, 0, 4 * $urandom_range(0, 3));
        8:       imem[i] = {6'h3E, 26'($urandom)};
        default: imem[i] = encI(6'h08, ra, rd, int'($urandom & 32'hFFFF));
      endcase
    end
    for (int r = 1; r < 8; r++) imem[39 + r] = encI(6'h2B, 0, r, 4 * (55 + r));
  endtask

  initial begin
    void'($urandom(32'd20240611));

    // R5: back-to-back independent stores, one per cycle, MEM at fetch+3
    clearProg();
    for (int i = 0; i < 4; i++) imem[i] = encI(6'h2B, 0, 0, 4 * i);
    runDut(30, 1'b1);
    chk(logPc[0] == 0, "R1", "first fetch address", logPc[0], 0);
    chk(logWe[2] == 1'b0, "R5", "no store before fill", {31'd0, logWe[2]}, 0);
    for (int c = 3; c < 7; c++)
      chk(logWe[c] && logAddr[c] == 32'(4 * (c - 3)), "R5", "store per cycle", logAddr[c], 32'(4 * (c - 3)));
    chk(logWe[7] == 1'b0, "R5", "drain after last store", {31'd0, logWe[7]}, 0);

    // R8: adjacent dependency, two bubbles
    clearProg();
    imem[0] = encI(6'h08, 0, 1, 5);
    imem[1] = encI(6'h2B, 0, 1, 16);
    runDut(30, 1'b0);
    chk(logPc[4] == 8, "R8", "fetch held during stall", logPc[4], 8);
    chk(logPc[5] == 12, "R8", "fetch resumes", logPc[5], 12);
    chk(!logWe[5] && logWe[6] && logData[6] == 5, "R8", "dependent store cycle/data", logData[6], 5);

    // R8: distance-two dependency, one bubble
    clearProg();
    imem[0] = encI(6'h08, 0, 2, 7);
    imem[1] = encI(6'h2B, 0, 0, 32);
    imem[2] = encI(6'h2B, 0, 2, 36);
    runDut(30, 1'b0);
    chk(logWe[4] && !logWe[5], "R8", "independent store then bubble", {31'd0, logWe[5]}, 0);
    chk(logWe[6] && logAddr[6] == 36 && logData[6] == 7, "R8", "store after one bubble", logData[6], 7);

    // R6 R7: taken branch squashes three younger instructions
    clearProg();
    imem[0] = encI(6'h04, 0, 0, 8);
    imem[1] = encI(6'h2B, 0, 0, 48);
    imem[2] = encI(6'h2B, 0, 0, 52);
    imem[3] = encI(6'h08, 0, 3, 9);
    imem[4] = encI(6'h2B, 0, 3, 56);
    modelRun();
    runDut(40, 1'b0);
    chk(logPc[4] == 12, "R6", "redirect to target", logPc[4], 12);
    chk(!logWe[4] && !logWe[5] && !logWe[6], "R7", "no store from squashed slots", {31'd0, logWe[5]}, 0);
    chk(dmem[12] == initMem[12] && dmem[13] == initMem[13], "R7", "squashed stores absent", dmem[12], initMem[12]);
    chk(dmem[14] == 9, "R6", "target path executed", dmem[14], 9);

    // R6: not-taken branch falls through
    clearProg();
    imem[0] = encI(6'h05, 0, 0, 8);
    imem[1] = encI(6'h08, 0, 4, 3);
    imem[2] = encI(6'h2B, 0, 4, 60);
    runDut(40, 1'b0);
    chk(dmem[15] == 3, "R6", "fall-through path executed", dmem[15], 3);

    // R9 R10: undefined opcode and writes to register 0
    clearProg();
    imem[0] = encI(6'h08, 0, 5, 6);
    imem[1] = encI(6'h3E, 0, 5, 16'h1234);
    imem[2] = encI(6'h2B, 0, 5, 64);
    imem[3] = encI(6'h08, 0, 0, 77);
    imem[4] = encI(6'h2B, 0, 0, 68);
    runDut(40, 1'b0);
    chk(dmem[16] == 6, "R10", "undefined opcode left register", dmem[16], 6);
    chk(dmem[17] == 0, "R9", "register 0 stays zero", dmem[17], 0);

    // R2 R3 R4 R11: random programs against the model
    for (int p = 0; p < 8; p++) begin
      genRandom();
      modelRun();
      runDut(400, 1'b0);
      cmpMem("R11", $sformatf("random program %0d final memory", p));
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule